// File: doc/BRIEF.md
# Fall-Through Bubble Stack

This block is the storage core of a small first-in first-out buffer. It holds fourteen 4-bit words in a column of slots, and each slot has its own occupied flag. A word written into the top slot sinks on its own, one slot per clock, as long as the slot beneath it is free. It stops only behind a word that is already waiting. The word in the bottom slot is offered to an output stage, which removes it with a pop.

The block has no read pointer and no write pointer. Its state is the set of occupied flags, so the time a word takes to cross the column depends on how many words sit below it. An input register in front and an output register behind can be joined to the column. Together they give a buffer of sixteen words. The input stage watches the top-empty indication and pushes when it is high. The output stage watches the bottom-valid indication and pops when it needs a word.

Top module: `fall_through_stack`

## Requirements
- R1: The column stores DEPTH (default 14) words of WIDTH (default 4) bits. With no pops, exactly 14 pushed words are held and no more are accepted.
- R2: `top_empty` is high exactly when the top slot is free. A push is accepted on a rising clock edge only when `push_valid` and `top_empty` are both high. A push offered while `top_empty` is low changes nothing.
- R3: On every clock edge, each occupied slot whose lower neighbour is free moves its word down by one slot. All such moves happen at the same edge. A word pushed into an empty column appears at the bottom DEPTH-1 edges after the edge that accepted it.
- R4: No word is overwritten, duplicated or lost. Words leave the bottom in the order they were pushed, under any pattern of pushes and pops.
- R5: A pop removes the bottom word on a rising edge only when `bot_valid` is high. A pop while `bot_valid` is low has no effect.
- R6: When a pop removes the bottom word and the slot directly above is occupied, that word moves into the bottom slot at the same edge, so `bot_valid` stays high.
- R7: An active-low reset clears every occupied flag, which gives `top_empty`=1 and `bot_valid`=0. Reset leaves stored data unchanged, so `bot_data` keeps its value.
- R8: `bot_valid` shows whether the bottom slot is occupied. `bot_data` always shows the contents of the bottom slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the occupied flags |
| push_valid | input | 1 | Input stage offers a word |
| push_data | input | WIDTH | Word offered for the top slot |
| top_empty | output | 1 | Top slot free, a push will be taken |
| pop | input | 1 | Output stage takes the bottom word |
| bot_valid | output | 1 | Bottom slot holds a word |
| bot_data | output | WIDTH | Contents of the bottom slot |

## Verification
The assertions check on every cycle that the word count changes only by accepted pushes and pops, that every word with a free slot beneath it moves down by one with its data intact, that an accepted push fills the top slot, and that a pop either empties the bottom slot or refills it from above. The bench scenarios cover what those local rules cannot show. These are the end-to-end latency of a lone word, the hard limit of 14 words, the data kept through a reset, and the order of words over long random push and pop sequences checked against a scoreboard.

// File: rtl/fts_pkg.sv
package fts_pkg;

  // Decide whether one slot's word moves down at the coming edge.
  // A slot below is usable if it is empty, or if it is the bottom slot
  // and its word is being popped at the same edge.
  function automatic logic fts_slot_moves(input logic occ_here,
                                          input logic occ_below,
                                          input logic below_is_bottom,
                                          input logic pop_fire);
    logic below_free;
    below_free = !occ_below || (below_is_bottom && pop_fire);
    return occ_here && below_free;
  endfunction

  // Accepted handshakes.
  function automatic logic fts_fire(input logic req, input logic ok);
    return req && ok;
  endfunction

endpackage

// File: rtl/fts_slot.sv
module fts_slot #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arrive,
  input  logic             leave,
  input  logic [WIDTH-1:0] din,
  output logic             occ,
  output logic [WIDTH-1:0] dout
);

  // Occupancy is the only reset state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      occ <= 1'b0;
    else if (arrive)
      occ <= 1'b1;
    else if (leave)
      occ <= 1'b0;
  end

  // Data is captured on arrival and never cleared.
  always_ff @(posedge clk) begin
    if (arrive)
      dout <= din;
  end

endmodule

// File: rtl/fts_advance.sv
module fts_advance #(
  parameter int DEPTH = 14
) (
  input  logic [DEPTH-1:0] occ,
  input  logic             push_valid,
  input  logic             pop,
  output logic             push_fire,
  output logic             pop_fire,
  output logic [DEPTH-2:0] moves
);
  import fts_pkg::*;

  assign push_fire = fts_fire(push_valid, !occ[0]);
  assign pop_fire  = fts_fire(pop, occ[DEPTH-1]);

  for (genvar i = 0; i < DEPTH-1; i++) begin : g_move
    assign moves[i] = fts_slot_moves(occ[i], occ[i+1], (i+1 == DEPTH-1), pop_fire);
  end

endmodule

// File: rtl/fall_through_stack.sv
module fall_through_stack #(
  parameter int DEPTH = 14,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             top_empty,
  input  logic             pop,
  output logic             bot_valid,
  output logic [WIDTH-1:0] bot_data
);
  localparam int LAST = DEPTH - 1;

  // Named internal events, also watched by the checker.
  logic [DEPTH-1:0]       occ;
  logic [DEPTH*WIDTH-1:0] slot_data;
  logic [DEPTH-2:0]       moves;
  logic                   push_fire;
  logic                   pop_fire;
  logic [DEPTH-1:0]       arrive;
  logic [DEPTH-1:0]       leave;

  fts_advance #(.DEPTH(DEPTH)) u_adv (
    .occ        (occ),
    .push_valid (push_valid),
    .pop        (pop),
    .push_fire  (push_fire),
    .pop_fire   (pop_fire),
    .moves      (moves)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WIDTH-1:0] din;
    if (i == 0) begin : g_top
      assign arrive[i] = push_fire;
      assign din       = push_data;
    end else begin : g_mid
      assign arrive[i] = moves[i-1];
      assign din       = slot_data[(i-1)*WIDTH +: WIDTH];
    end
    if (i == LAST) begin : g_bot
      assign leave[i] = pop_fire;
    end else begin : g_up
      assign leave[i] = moves[i];
    end
    fts_slot #(.WIDTH(WIDTH)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .arrive (arrive[i]),
      .leave  (leave[i]),
      .din    (din),
      .occ    (occ[i]),
      .dout   (slot_data[i*WIDTH +: WIDTH])
    );
  end

  assign top_empty = !occ[0];
  assign bot_valid = occ[LAST];
  assign bot_data  = slot_data[LAST*WIDTH +: WIDTH];

endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
  parameter int DEPTH = 14,
  parameter int WIDTH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   push_valid,
  input logic                   pop,
  input logic                   top_empty,
  input logic                   bot_valid,
  input logic [WIDTH-1:0]       bot_data,
  input logic [DEPTH-1:0]       occ,
  input logic [DEPTH*WIDTH-1:0] slot_data,
  input logic [DEPTH-2:0]       moves,
  input logic                   push_fire,
  input logic                   pop_fire
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R4: the word count changes only through accepted pushes and pops
  a_r4_count_conserved: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ($countones(occ) == $past($countones(occ)) + int'($past(push_fire)) - int'($past(pop_fire))));

  // R2: an accepted push fills the top slot
  a_r2_push_fills_top: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && top_empty) |=> !top_empty);

  // R5: a pop with nothing arriving from above empties the bottom slot
  a_r5_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && bot_valid && !moves[DEPTH-2]) |=> !bot_valid);

  // R6: a pop with a word above refills the bottom with that word
  a_r6_pop_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && bot_valid && occ[DEPTH-2]) |=>
      (bot_valid && bot_data == $past(slot_data[(DEPTH-2)*WIDTH +: WIDTH])));

  for (genvar i = 0; i < DEPTH-1; i++) begin : g_chk
    // R3: a word with a free slot beneath it advances by one, intact
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[i] && !occ[i+1]) |=>
        (occ[i+1] && slot_data[(i+1)*WIDTH +: WIDTH] == $past(slot_data[i*WIDTH +: WIDTH])));
  end

endmodule

bind fall_through_stack fts_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .pop        (pop),
  .top_empty  (top_empty),
  .bot_valid  (bot_valid),
  .bot_data   (bot_data),
  .occ        (occ),
  .slot_data  (slot_data),
  .moves      (moves),
  .push_fire  (push_fire),
  .pop_fire   (pop_fire)
);

// File: tb/fall_through_stack_tb.sv
module fall_through_stack_tb;
  localparam int D = 14;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [W-1:0] push_data = '0;
  logic pop = 1'b0;
  logic top_empty, bot_valid;
  logic [W-1:0] bot_data;

  int checks = 0;
  int failures = 0;

  // Independent model: slot table indexed top (0) to bottom (D-1).
  bit       m_full [D];
  bit [W-1:0] m_word [D];
  int sb[$];

  always #2 clk = ~clk;

  fall_through_stack #(.DEPTH(D), .WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .top_empty(top_empty), .pop(pop), .bot_valid(bot_valid), .bot_data(bot_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, edge, compare at next negedge.
  task automatic step(input bit pv, input bit [W-1:0] pd, input bit pp);
    bit nf [D];
    bit [W-1:0] nw [D];
    bit take_in, take_out;
    push_valid = pv; push_data = pd; pop = pp;
    take_in  = pv && !m_full[0];
    take_out = pp && m_full[D-1];
    if (take_out) begin
      if (sb.size() == 0) check(0, "R4 pop from empty scoreboard", 1, 0);
      else begin
        int exp_w = sb.pop_front();
        check(bot_data == W'(exp_w), "R4 order", int'(bot_data), exp_w);
      end
    end
    if (take_in) sb.push_back(int'(pd));
    for (int i = 0; i < D; i++) begin
      nf[i] = m_full[i]; nw[i] = m_word[i];
    end
    if (take_out) nf[D-1] = 0;
    for (int i = D-2; i >= 0; i--) begin
      bit room = !m_full[i+1] || (i == D-2 && take_out);
      if (m_full[i] && room) begin
        nf[i+1] = 1; nw[i+1] = m_word[i]; nf[i] = 0;
      end
    end
    if (take_in) begin nf[0] = 1; nw[0] = pd; end
    for (int i = 0; i < D; i++) begin
      m_full[i] = nf[i]; m_word[i] = nw[i];
    end
    @(posedge clk);
    @(negedge clk);
    check(bot_valid == m_full[D-1], "R8 bot_valid", int'(bot_valid), int'(m_full[D-1]));
    check(top_empty == !m_full[0], "R2 top_empty", int'(top_empty), int'(!m_full[0]));
    if (m_full[D-1])
      check(bot_data == m_word[D-1], "R3 bottom word", int'(bot_data), int'(m_word[D-1]));
  endtask

  task automatic do_reset();
    push_valid = 0; pop = 0; rst_n = 0;
    for (int i = 0; i < D; i++) m_full[i] = 0;
    sb.delete();
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(top_empty == 1, "R7 top_empty after reset", int'(top_empty), 1);
    check(bot_valid == 0, "R7 bot_valid after reset", int'(bot_valid), 0);
  endtask

  task automatic t_latency();
    int edges = 0;
    step(1, 4'hA, 0);
    while (!bot_valid && edges < 40) begin
      step(0, 0, 0);
      edges++;
    end
    check(edges == D-1, "R3 lone word latency", edges, D-1);
    check(bot_data == 4'hA, "R8 bot_data", int'(bot_data), 10);
    step(0, 0, 1);
    check(bot_valid == 0, "R5 pop empties bottom", int'(bot_valid), 0);
  endtask

  task automatic t_fill_and_drain();
    int v = 1;
    int guard = 0;
    while (sb.size() < D && guard < 200) begin
      bit acc = !m_full[0];
      step(1, W'(v), 0);
      if (acc) v++;
      guard++;
    end
    for (int k = 0; k < 20; k++) step(0, 0, 0);
    check(top_empty == 0, "R1 full column", int'(top_empty), 0);
    for (int k = 0; k < 5; k++) step(1, 4'hF, 0);
    check(sb.size() == D, "R1 capacity held", sb.size(), D);
    check(top_empty == 0, "R2 push ignored when full", int'(top_empty), 0);
    step(0, 0, 1);
    check(bot_valid == 1, "R6 refill on pop", int'(bot_valid), 1);
    check(bot_data == 4'h2, "R6 next word", int'(bot_data), 2);
    guard = 0;
    while (sb.size() > 0 && guard < 200) begin
      step(0, 0, 1);
      guard++;
    end
    check(sb.size() == 0, "R4 drained in order", sb.size(), 0);
  endtask

  task automatic t_empty_pop();
    for (int k = 0; k < 3; k++) step(0, 0, 1);
    check(bot_valid == 0, "R5 empty pop ignored", int'(bot_valid), 0);
    step(1, 4'h5, 0);
    for (int k = 0; k < D; k++) step(0, 0, 0);
    check(bot_valid == 1 && bot_data == 4'h5, "R5 word intact after empty pops", int'(bot_data), 5);
  endtask

  task automatic t_reset_data();
    check(bot_data == 4'h5, "R7 bottom word before reset", int'(bot_data), 5);
    do_reset();
    check(bot_valid == 0, "R7 occupancy cleared", int'(bot_valid), 0);
    check(bot_data == 4'h5, "R7 data kept through reset", int'(bot_data), 5);
  endtask

  task automatic t_random();
    for (int k = 0; k < 4000; k++) begin
      bit pv = ($urandom_range(0, 9) < 6);
      bit pp = ($urandom_range(0, 9) < ((k / 500) % 2 == 0 ? 3 : 8));
      step(pv, W'($urandom_range(0, 15)), pp);
    end
    for (int k = 0; k < 100; k++) step(0, 0, 1);
    check(sb.size() == 0, "R4 random order preserved", sb.size(), 0);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(7));
    @(negedge clk);
    t_reset_state();
    t_latency();
    t_fill_and_drain();
    t_empty_pop();
    t_reset_data();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule